// File: doc/BRIEF.md
# PIN Pad Key Event Decoder

This block sits behind a PS/2 receiver. It turns the stream of set-2 scan-code bytes into single key-press events for a numeric PIN entry pad. Each byte arrives with a one-cycle valid strobe. The decoder tracks the two prefix bytes of the code set: the extended prefix and the break (release) prefix. It also keeps the code of the key that is currently held. Because of this, the repeats a keyboard sends while a key stays down produce no further events.

Every accepted press leaves the block as a one-cycle event pulse. The pulse carries a key class and a 4-bit digit value. The digit keys of the main row and of the numeric keypad both give the values 0 to 9. There are three command keys: confirm, cancel/lock and change-PIN. Any other key is reported with the class "other". Key releases produce no event.

Top module: `keypad_event_decoder`

## Requirements
- R1: An accepted press raises `evt_valid` for exactly one cycle, in the cycle after the clock edge that took the byte. `evt_class` is encoded as digit=0, confirm=1, cancel=2, change-PIN=3, other=4. For any class other than digit, `evt_digit` is 0.
- R2: The byte 0xE0 produces no event. It sets an extended flag. The next accepted code is decoded as if bit 7 of that code were set, and accepting the code clears the flag.
- R3: The byte 0xF0 produces no event and arms a release. The next byte, whatever its value (0xE0 included), produces no event. That byte clears the remembered pressed code, the extended flag and the armed release.
- R4: A byte equal to the remembered pressed code produces no event and changes no state. A code becomes remembered when it is accepted, so a held key produces only one event.
- R5: Any other byte of 0x80 or above produces no event. It leaves the extended flag and the pressed code unchanged.
- R6: The main-row codes 0x16, 0x1E, 0x26, 0x25, 0x2E, 0x36, 0x3D, 0x3E and 0x46 give the digits 1 to 9, and 0x45 gives 0.
- R7: The keypad codes 0x69, 0x72, 0x7A, 0x6B, 0x73, 0x74, 0x6C, 0x75 and 0x7D give the digits 1 to 9, and 0x70 gives 0.
- R8: The code 0x5A gives confirm. The extended sequence 0xE0 0x5A also gives confirm.
- R9: The codes 0x76 and 0x77 give cancel, and 0x07 gives change-PIN.
- R10: Every other accepted code gives the class other. This includes the extended forms of digit and cancel codes.
- R11: A synchronous active-high reset clears the extended flag, the armed release and the pressed code, and holds the event outputs at zero.
- R12: In a cycle with no strobe, nothing changes, and the next cycle shows `evt_valid`, `evt_class` and `evt_digit` all at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received scan-code byte |
| evt_valid | output | 1 | One-cycle key-press event |
| evt_class | output | 3 | Key class of the event |
| evt_digit | output | 4 | Digit value when the class is digit |

## Verification
All twenty digit codes are applied, each followed by its release, so that any mix-up between the main-row and keypad tables shows up as a wrong digit value. Back-to-back repeats of one code separate repeat suppression from release handling. Prefixes are then interleaved with discarded high bytes, and a prefix is consumed by a release. These patterns show whether the extended flag survives discards, is cleared by release, and folds into the right code. Resets placed between a prefix or a press and the next code confirm that the state is cleared.

// File: rtl/kev_pkg.sv
`timescale 1ns/1ps
package kev_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIGIT_W = 4;
  localparam int CLASS_W = 3;
  localparam int EXT_POS = BYTE_W - 1;

  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hE0;
  localparam logic [BYTE_W-1:0] PFX_REL = 8'hF0;

  typedef enum logic [CLASS_W-1:0] {
    KC_DIGIT   = 3'd0,
    KC_CONFIRM = 3'd1,
    KC_CANCEL  = 3'd2,
    KC_CHANGE  = 3'd3,
    KC_OTHER   = 3'd4
  } key_class_e;

  typedef struct packed {
    key_class_e         cls;
    logic [DIGIT_W-1:0] digit;
  } key_info_t;
endpackage

// File: rtl/kev_prefix_track.sv
`timescale 1ns/1ps
module kev_prefix_track
  import kev_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              press_fire,
  output logic [BYTE_W-1:0] press_code
);
  logic              ext_q, ext_d;
  logic              rel_q, rel_d;
  logic [BYTE_W-1:0] held_q, held_d;

  always_comb begin
    ext_d      = ext_q;
    rel_d      = rel_q;
    held_d     = held_q;
    press_fire = 1'b0;
    if (in_valid) begin
      if (rel_q) begin
        rel_d  = 1'b0;
        ext_d  = 1'b0;
        held_d = '0;
      end else if (in_byte == held_q) begin
        held_d = held_q;
      end else if (in_byte == PFX_EXT) begin
        ext_d = 1'b1;
      end else if (in_byte == PFX_REL) begin
        rel_d = 1'b1;
      end else if (!in_byte[EXT_POS]) begin
        held_d     = in_byte;
        ext_d      = 1'b0;
        press_fire = 1'b1;
      end
    end
  end

  assign press_code = {ext_q, in_byte[EXT_POS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q  <= 1'b0;
      rel_q  <= 1'b0;
      held_q <= '0;
    end else begin
      ext_q  <= ext_d;
      rel_q  <= rel_d;
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/kev_code_map.sv
`timescale 1ns/1ps
module kev_code_map
  import kev_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output key_info_t         info
);
  always_comb begin
    info.cls   = KC_DIGIT;
    info.digit = '0;
    unique case (code)
      8'h45, 8'h70: info.digit = 4'd0;
      8'h16, 8'h69: info.digit = 4'd1;
      8'h1E, 8'h72: info.digit = 4'd2;
      8'h26, 8'h7A: info.digit = 4'd3;
      8'h25, 8'h6B: info.digit = 4'd4;
      8'h2E, 8'h73: info.digit = 4'd5;
      8'h36, 8'h74: info.digit = 4'd6;
      8'h3D, 8'h6C: info.digit = 4'd7;
      8'h3E, 8'h75: info.digit = 4'd8;
      8'h46, 8'h7D: info.digit = 4'd9;
      8'h5A, 8'hDA: info.cls   = KC_CONFIRM;
      8'h76, 8'h77: info.cls   = KC_CANCEL;
      8'h07:        info.cls   = KC_CHANGE;
      default:      info.cls   = KC_OTHER;
    endcase
  end
endmodule

// File: rtl/kev_event_reg.sv
`timescale 1ns/1ps
module kev_event_reg
  import kev_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  key_info_t          info,
  output logic               evt_valid,
  output logic [CLASS_W-1:0] evt_class,
  output logic [DIGIT_W-1:0] evt_digit
);
  always_ff @(posedge clk) begin
    if (rst || !fire) begin
      evt_valid <= 1'b0;
      evt_class <= '0;
      evt_digit <= '0;
    end else begin
      evt_valid <= 1'b1;
      evt_class <= info.cls;
      evt_digit <= info.digit;
    end
  end
endmodule

// File: rtl/keypad_event_decoder.sv
`timescale 1ns/1ps
module keypad_event_decoder
  import kev_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_valid,
  input  logic [BYTE_W-1:0]  byte_data,
  output logic               evt_valid,
  output logic [CLASS_W-1:0] evt_class,
  output logic [DIGIT_W-1:0] evt_digit
);
  logic              fire;
  logic [BYTE_W-1:0] code;
  key_info_t         info;

  kev_prefix_track u_track (
    .clk(clk), .rst(rst), .in_valid(byte_valid), .in_byte(byte_data),
    .press_fire(fire), .press_code(code)
  );

  kev_code_map u_map (.code(code), .info(info));

  kev_event_reg u_out (
    .clk(clk), .rst(rst), .fire(fire), .info(info),
    .evt_valid(evt_valid), .evt_class(evt_class), .evt_digit(evt_digit)
  );
endmodule

// File: rtl/kev_checker.sv
`timescale 1ns/1ps
module kev_checker (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       evt_valid,
  input logic [2:0] evt_class,
  input logic [3:0] evt_digit
);
  p_event_after_byte_r1: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(byte_valid));

  p_nondigit_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_class != 3'd0) |-> evt_digit == 4'd0);

  p_ext_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data == 8'hE0) |=> !evt_valid);

  p_rel_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data == 8'hF0) |=> !evt_valid);

  p_repeat_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && byte_valid && byte_data == $past(byte_data)) |=> !evt_valid);

  p_high_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7]) |=> !evt_valid);

  p_class_range_r10: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> evt_class <= 3'd4);

  p_digit_range_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_class == 3'd0) |-> evt_digit <= 4'd9);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> (!evt_valid && evt_class == 3'd0 && evt_digit == 4'd0));
endmodule

bind keypad_event_decoder kev_checker u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
  .evt_valid(evt_valid), .evt_class(evt_class), .evt_digit(evt_digit)
);

// File: tb/keypad_event_decoder_test.sv
`timescale 1ns/1ps
module keypad_event_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       evt_valid;
  logic [2:0] evt_class;
  logic [3:0] evt_digit;

  always #2.5 clk = ~clk;

  keypad_event_decoder uut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .evt_valid(evt_valid), .evt_class(evt_class), .evt_digit(evt_digit)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  int    m_ext = 0, m_rel = 0, m_held = 0;
  int    x_v = 0, x_c = 0, x_d = 0;
  string x_req = "R11";

  int main_row[10] = '{'h16, 'h1E, 'h26, 'h25, 'h2E, 'h36, 'h3D, 'h3E, 'h46, 'h45};
  int pad_row[10]  = '{'h69, 'h72, 'h7A, 'h6B, 'h73, 'h74, 'h6C, 'h75, 'h7D, 'h70};

  // class: digit=0 confirm=1 cancel=2 change=3 other=4
  task automatic classify(input int code, output int c, output int d);
    c = 4; d = 0;
    for (int i = 0; i < 10; i++)
      if (code == main_row[i] || code == pad_row[i]) begin c = 0; d = (i + 1) % 10; end
    if (code == 'h5A || code == 'hDA) c = 1;
    if (code == 'h76 || code == 'h77) c = 2;
    if (code == 'h07) c = 3;
  endtask

  task automatic step(input bit r, input bit v, input int b, input string req);
    @(negedge clk);
    vectors++;
    if (evt_valid !== x_v[0] || evt_class !== x_c[2:0] || evt_digit !== x_d[3:0]) begin
      fails++;
      $display("FAIL %s: got v=%0b c=%0d d=%0d expected v=%0d c=%0d d=%0d",
               x_req, evt_valid, evt_class, evt_digit, x_v, x_c, x_d);
    end
    rst = r; byte_valid = v; byte_data = b[7:0];
    x_v = 0; x_c = 0; x_d = 0; x_req = req;
    if (r) begin
      m_ext = 0; m_rel = 0; m_held = 0;
    end else if (v) begin
      if (m_rel != 0) begin m_rel = 0; m_ext = 0; m_held = 0; end
      else if (b == m_held) begin end
      else if (b == 'hE0) m_ext = 1;
      else if (b == 'hF0) m_rel = 1;
      else if (b >= 'h80) begin end
      else begin
        classify(b + 128 * m_ext, x_c, x_d);
        x_v = 1; m_held = b; m_ext = 0;
      end
    end
  endtask

  task automatic send(input int b, input string req);
    step(0, 1, b, req);
  endtask

  task automatic tap(input int b, input string req);
    send(b, req); send('hF0, "R3"); send(b, "R3");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R11");
    step(0, 0, 0, "R12");
    step(0, 0, 0, "R12");
    for (int i = 0; i < 10; i++) tap(main_row[i], "R6");
    for (int i = 0; i < 10; i++) tap(pad_row[i], "R7");
    // repeats of a held key
    send('h16, "R4"); send('h16, "R4"); send('h16, "R4");
    step(0, 0, 0, "R12"); send('h16, "R4");
    send('hF0, "R3"); send('h16, "R3"); send('h16, "R4");
    // confirm, plain and extended
    send('h5A, "R8"); send('hE0, "R2"); send('h1E, "R2");
    send('hE0, "R8"); send('h5A, "R8");
    tap('h76, "R9"); tap('h77, "R9"); send('h07, "R9"); send('h07, "R4");
    // other codes and extended non-confirm codes
    send('h1C, "R10"); send('hE0, "R2"); send('h75, "R10");
    send('hE0, "R2"); send('h76, "R10");
    // high bytes discarded, extended flag kept
    send('h80, "R5"); send('hAA, "R5"); send('hE0, "R5");
    send('h90, "R5"); send('hFF, "R5"); send('h7A, "R5");
    // release consumes a prefix and clears the flag
    send('hE0, "R2"); send('hF0, "R3"); send('hE0, "R3"); send('h7A, "R3");
    // gaps between strobes
    step(0, 0, 0, "R12"); step(0, 0, 'h26, "R12"); send('h26, "R1");
    // reset clears held code and extended flag
    send('h26, "R4"); step(1, 0, 0, "R11"); send('h26, "R11");
    send('hE0, "R2"); step(1, 1, 'h7A, "R11"); send('h7A, "R11");
    for (int i = 0; i < 40; i++) begin
      int b = (i * 37 + 11) % 256;
      send(b, "R1");
    end
    step(0, 0, 0, "R12");
    step(0, 0, 0, "R12");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule